// File: doc/BRIEF.md
# Parallel Bus Register Slave

This block is a memory-mapped register slave that a host processor reaches over a plain parallel external memory bus. The host supplies a bus clock, four active-low control strobes (chip select, address strobe, write enable, output enable), an address and a byte of write data. The block sends back a byte of read data together with a tri-state enable for the data pad, which sits at the chip edge.

The address space holds three kinds of window. A fixed identity window returns constant configuration and version bytes. A diagnostic scratch window and a small extended page hold bytes that the host can read and write. Four reserved register groups, like every address outside a window, ignore writes and read back zero.

A write takes effect on the single rising edge of the bus clock where the write strobes are all asserted, using the address and data present at that edge. A read latches the address on the strobed edge. From then on the selected register is driven for as long as output enable stays low, even after chip select has gone back high.

Top module: `par_bus_regslave`

## Requirements
- R1: All four control inputs are active low. A write stores `bus_data_i` into the addressed register on a rising `clk_bus` edge where `cs_n`, `ads_n` and `we_n` are 0 and `oe_n` is 1.
- R2: On an edge where `cs_n` is 1, `ads_n` is 1, `we_n` is 1 or `oe_n` is 0, no register changes.
- R3: The 16 diagnostic locations at addresses 0x70 to 0x7F each return the last byte written to them, for every value from 0x00 to 0xFF.
- R4: The 4 extended page locations at addresses 0x80 to 0x83 each return their own last written byte, and a write to one leaves the other three unchanged.
- R5: Addresses 0x00, 0x01, 0x02 and 0x03 read as 0x3D, 0x01, 0x00 and 0x00. They keep these values whatever is written anywhere.
- R6: The read address is latched on a rising edge where `cs_n` and `ads_n` are both 0. While `oe_n` is 0, `bus_data_o` carries the register at the latched address and `bus_data_oe` is 1, even after `cs_n` and `ads_n` rise and the address bus changes.
- R7: While `oe_n` is 1, `bus_data_oe` is 0, so the data pad is at high impedance. This includes every write cycle.
- R8: The reserved groups at 0x10 to 0x4F, the rest of the identity window (0x04 to 0x0F) and all unmapped addresses (for example 0x50 to 0x6F and 0x84 to 0xFF) read as 0x00 and ignore writes.
- R9: A synchronous active-low `rst_n` clears every diagnostic and page location to 0x00 and the latched address to 0x00, and it holds `bus_data_oe` at 0 while asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock; every register samples on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ads_n | input | 1 | Address strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (8) | Register address |
| bus_data_i | input | DATA_W (8) | Write data from the pad |
| bus_data_o | output | DATA_W (8) | Read data to the pad |
| bus_data_oe | output | 1 | Pad tri-state enable; 1 drives `bus_data_o` |

## Verification
The bench moves the address bus away after the latching edge, while output enable is still low. A slave that decoded the live address instead of the latched one would return the wrong byte. It writes 0x00, 0xFF and walking values into every scratch and page location, and checks neighbours after a single page write; shared or aliased storage would show up as corrupted neighbours. Writes with only one strobe wrong, or with output enable low, must leave the data unchanged. Writes aimed at the identity bytes, reserved groups and window edges (0x6F, 0x84) must not appear anywhere, and a decoder with an off-by-one bound would store or return data there. A reset in the middle of the run must zero the scratch data while the identity bytes survive, and the pad must be released both during write cycles and while reset is held.

// File: rtl/pbrs_pkg.sv
// Shared types and constants for the parallel bus register slave.
// Assumes: identity bytes are at most 8 bits wide and zero-extended.
package pbrs_pkg;

    // Which window an address falls into
    typedef enum logic [2:0] {
        WIN_NONE = 3'd0,
        WIN_CFG  = 3'd1,
        WIN_RSVD = 3'd2,
        WIN_DIAG = 3'd3,
        WIN_PAGE = 3'd4
    } win_e;

    // Constant contents of the identity window, by offset
    function automatic logic [7:0] cfg_byte(input int unsigned offs);
        case (offs)
            0:       return 8'h3D;
            1:       return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/pbrs_decode.sv
// Address decoder: classifies an address into a window and returns the
// offset inside it. Purely combinational.
// Assumes: windows do not overlap and each fits in the address space.
module pbrs_decode
    import pbrs_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int unsigned CFG_BASE   = 'h00,
    parameter int unsigned CFG_SPAN   = 'h10,
    parameter int unsigned RSVD_BASE  = 'h10,
    parameter int unsigned RSVD_SPAN  = 'h40,
    parameter int unsigned DIAG_BASE  = 'h70,
    parameter int unsigned DIAG_DEPTH = 16,
    parameter int unsigned PAGE_BASE  = 'h80,
    parameter int unsigned PAGE_DEPTH = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic [ADDR_W-1:0] offs
);

    localparam int PAD_W = 32 - ADDR_W;

    logic [31:0] a_ext;

    // Widen the address once so every comparison is 32 bits
    always_comb a_ext = {{PAD_W{1'b0}}, addr};

    // Range match against each window, first hit wins
    always_comb begin
        win  = WIN_NONE;
        offs = '0;
        if (a_ext >= CFG_BASE && a_ext < CFG_BASE + CFG_SPAN) begin
            win  = WIN_CFG;
            offs = ADDR_W'(a_ext - CFG_BASE);
        end else if (a_ext >= RSVD_BASE && a_ext < RSVD_BASE + RSVD_SPAN) begin
            win  = WIN_RSVD;
            offs = ADDR_W'(a_ext - RSVD_BASE);
        end else if (a_ext >= DIAG_BASE && a_ext < DIAG_BASE + DIAG_DEPTH) begin
            win  = WIN_DIAG;
            offs = ADDR_W'(a_ext - DIAG_BASE);
        end else if (a_ext >= PAGE_BASE && a_ext < PAGE_BASE + PAGE_DEPTH) begin
            win  = WIN_PAGE;
            offs = ADDR_W'(a_ext - PAGE_BASE);
        end
    end

endmodule

// File: rtl/pbrs_bank.sv
// Bank of writable byte registers with one write port and one read port.
// Assumes: indices are already range-checked by the decoder.
module pbrs_bank #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DEPTH-1:0][DATA_W-1:0] mem_q;

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        // One storage byte: cleared by reset, loaded when selected
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[k] <= '0;
            else if (wr_en && wr_idx == IDX_W'(k))
                mem_q[k] <= wr_data;
        end
    end

    // Read selection by index compare
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < DEPTH; k++)
            if (rd_idx == IDX_W'(k))
                rd_data = mem_q[k];
    end

    // R3 / R4: a granted write lands in the selected entry
    p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(wr_idx)] == $past(wr_data));

    // R2: no write grant, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem_q));

endmodule

// File: rtl/pbrs_bus_io.sv
// Bus side: latches the read address on the strobed edge and controls
// the data pad enable from output enable.
// Assumes: the pad buffer sits outside and obeys data_oe.
module pbrs_bus_io #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ads_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] rd_mux,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe
);

    // Capture the address on a strobed edge, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (!cs_n && !ads_n)
            addr_q <= addr;
    end

    // Pad drive: only with output enable low and out of reset
    always_comb begin
        data_oe = rst_n && !oe_n;
        data_o  = data_oe ? rd_mux : '0;
    end

    // R6: the latched address follows the strobed capture
    p_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ads_n) |=> addr_q == $past(addr));

    // R6: without a strobe the latch keeps its value
    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || ads_n) |=> $stable(addr_q));

endmodule

// File: rtl/par_bus_regslave.sv
// Memory-mapped register slave on a strobed parallel bus: a constant
// identity window, a diagnostic scratch bank and an extended page.
// Assumes: one bus clock domain; the data pad is tri-stated outside.
module par_bus_regslave
    import pbrs_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int DIAG_DEPTH = 16,
    parameter int PAGE_DEPTH = 4
) (
    input  logic              clk_bus,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ads_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_data_oe
);

    localparam int unsigned CFG_BASE  = 'h00;
    localparam int unsigned CFG_SPAN  = 'h10;
    localparam int unsigned CFG_BYTES = 4;
    localparam int unsigned RSVD_BASE = 'h10;
    localparam int unsigned RSVD_SPAN = 'h40;
    localparam int unsigned DIAG_BASE = 'h70;
    localparam int unsigned PAGE_BASE = 'h80;

    win_e              wr_win, rd_win;
    logic [ADDR_W-1:0] wr_offs, rd_offs, addr_q;
    logic              wr_strobe;
    logic [DATA_W-1:0] diag_rd, page_rd, rd_mux;

    // Decode of the live address, for writes
    pbrs_decode #(
        .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .CFG_SPAN(CFG_SPAN),
        .RSVD_BASE(RSVD_BASE), .RSVD_SPAN(RSVD_SPAN),
        .DIAG_BASE(DIAG_BASE), .DIAG_DEPTH(DIAG_DEPTH),
        .PAGE_BASE(PAGE_BASE), .PAGE_DEPTH(PAGE_DEPTH)
    ) u_wr_dec (
        .addr(addr), .win(wr_win), .offs(wr_offs)
    );

    // Decode of the latched address, for reads
    pbrs_decode #(
        .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .CFG_SPAN(CFG_SPAN),
        .RSVD_BASE(RSVD_BASE), .RSVD_SPAN(RSVD_SPAN),
        .DIAG_BASE(DIAG_BASE), .DIAG_DEPTH(DIAG_DEPTH),
        .PAGE_BASE(PAGE_BASE), .PAGE_DEPTH(PAGE_DEPTH)
    ) u_rd_dec (
        .addr(addr_q), .win(rd_win), .offs(rd_offs)
    );

    // Write qualifier: all write strobes low, output enable high
    always_comb wr_strobe = !cs_n && !ads_n && !we_n && oe_n;

    pbrs_bank #(.DATA_W(DATA_W), .DEPTH(DIAG_DEPTH), .IDX_W(ADDR_W)) u_diag (
        .clk(clk_bus), .rst_n(rst_n),
        .wr_en(wr_strobe && wr_win == WIN_DIAG),
        .wr_idx(wr_offs), .wr_data(bus_data_i),
        .rd_idx(rd_offs), .rd_data(diag_rd)
    );

    pbrs_bank #(.DATA_W(DATA_W), .DEPTH(PAGE_DEPTH), .IDX_W(ADDR_W)) u_page (
        .clk(clk_bus), .rst_n(rst_n),
        .wr_en(wr_strobe && wr_win == WIN_PAGE),
        .wr_idx(wr_offs), .wr_data(bus_data_i),
        .rd_idx(rd_offs), .rd_data(page_rd)
    );

    // Read data select by window of the latched address
    always_comb begin
        case (rd_win)
            WIN_CFG:  rd_mux = (32'(rd_offs) < CFG_BYTES)
                               ? DATA_W'(cfg_byte(32'(rd_offs))) : '0;
            WIN_DIAG: rd_mux = diag_rd;
            WIN_PAGE: rd_mux = page_rd;
            default:  rd_mux = '0;
        endcase
    end

    pbrs_bus_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
        .clk(clk_bus), .rst_n(rst_n), .cs_n(cs_n), .ads_n(ads_n), .oe_n(oe_n),
        .addr(addr), .rd_mux(rd_mux), .addr_q(addr_q),
        .data_o(bus_data_o), .data_oe(bus_data_oe)
    );

    // R7: pad released whenever output enable is high
    p_release_r7: assert property (@(posedge clk_bus) disable iff (!rst_n)
        oe_n |-> !bus_data_oe);

    // R5: first identity byte seen on the pad
    p_ident_r5: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (bus_data_oe && addr_q == '0) |-> bus_data_o == DATA_W'(8'h3D));

    // R8: reserved and unmapped reads return zero
    p_zero_r8: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (bus_data_oe && (rd_win == WIN_NONE || rd_win == WIN_RSVD))
            |-> bus_data_o == '0);

    // R9: reset holds the pad released
    always_comb p_reset_r9: assert (rst_n || !bus_data_oe);

endmodule

// File: tb/test_par_bus_regslave.sv
module test_par_bus_regslave;

    logic       clk_bus = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ads_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [7:0] addr = '0, bus_data_i = '0;
    logic [7:0] bus_data_o;
    logic       bus_data_oe;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic       drv;
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    logic smp = 1'b0;
    logic [7:0] diag_m [16];
    logic [7:0] page_m [4];

    always #10 clk_bus = ~clk_bus;   // 50 MHz

    par_bus_regslave i_par_bus_regslave (
        .clk_bus(clk_bus), .rst_n(rst_n), .cs_n(cs_n), .ads_n(ads_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .bus_data_i(bus_data_i),
        .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe)
    );

    // Monitor: pops the expected item and compares at the falling edge
    always @(negedge clk_bus) begin
        if (smp) begin
            exp_t e;
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL monitor: sample with empty queue, actual oe=%0b data=%02h expected an item",
                         bus_data_oe, bus_data_o);
            end else begin
                e = exp_q.pop_front();
                if (bus_data_oe !== e.drv || (e.drv && bus_data_o !== e.val)) begin
                    n_fail++;
                    $display("FAIL %s: actual oe=%0b data=%02h expected oe=%0b data=%02h",
                             e.tag, bus_data_oe, bus_data_o, e.drv, e.val);
                end
            end
        end
    end

    task automatic sample(input logic drv, input logic [7:0] val, input string tag);
        exp_t e;
        e.drv = drv; e.val = val; e.tag = tag;
        exp_q.push_back(e);
        smp = 1'b1;
        @(negedge clk_bus);
        #1 smp = 1'b0;
    endtask

    // Driver: write cycle; pad must stay released during it (R7)
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d,
                             input logic c = 0, input logic s = 0,
                             input logic w = 0, input logic o = 1);
        @(posedge clk_bus); #1;
        addr = a; bus_data_i = d; cs_n = c; ads_n = s; we_n = w; oe_n = o;
        if (o) sample(1'b0, 8'h00, "R7 released during write");
        @(posedge clk_bus); #1;
        cs_n = 1; ads_n = 1; we_n = 1; oe_n = 1;
    endtask

    // Driver: read cycle; the address bus is moved after the latch (R6)
    task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk_bus); #1;
        addr = a; cs_n = 0; ads_n = 0; we_n = 1; oe_n = 0;
        @(posedge clk_bus); #1;
        cs_n = 1; ads_n = 1; addr = ~a;
        sample(1'b1, exp, tag);
        @(posedge clk_bus); #1;
        oe_n = 1;
        sample(1'b0, 8'h00, "R7 released after read");
    endtask

    task automatic do_reset();
        @(posedge clk_bus); #1;
        rst_n = 0;
        oe_n = 0;
        sample(1'b0, 8'h00, "R9 pad held off in reset");
        oe_n = 1;
        repeat (2) @(posedge clk_bus);
        #1 rst_n = 1;
        foreach (diag_m[k]) diag_m[k] = 8'h00;
        foreach (page_m[k]) page_m[k] = 8'h00;
    endtask

    task automatic finish_up();
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk_bus);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_up();
    end

    initial begin
        do_reset();
        // R9: reset state
        bus_read(8'h70, 8'h00, "R9 diag cleared");
        bus_read(8'h83, 8'h00, "R9 page cleared");
        // R5: identity bytes
        bus_read(8'h00, 8'h3D, "R5 ident 0");
        bus_read(8'h01, 8'h01, "R5 ident 1");
        bus_read(8'h02, 8'h00, "R5 ident 2");
        bus_read(8'h03, 8'h00, "R5 ident 3");
        // R1/R3: diagnostic patterns
        for (int i = 0; i < 16; i++) begin
            bus_write(8'(8'h70 + i), 8'(i)); diag_m[i] = 8'(i);
        end
        for (int i = 0; i < 16; i++) bus_read(8'(8'h70 + i), diag_m[i], "R1 R3 diag walk");
        for (int i = 0; i < 16; i++) begin
            bus_write(8'(8'h70 + i), 8'(255 - i)); diag_m[i] = 8'(255 - i);
        end
        for (int i = 0; i < 16; i++) bus_read(8'(8'h70 + i), diag_m[i], "R3 diag inverse");
        bus_write(8'h70, 8'h00); diag_m[0] = 8'h00;
        bus_write(8'h7F, 8'hFF); diag_m[15] = 8'hFF;
        bus_read(8'h70, 8'h00, "R3 diag 0x00");
        bus_read(8'h7F, 8'hFF, "R3 diag 0xFF");
        // R4: extended page
        for (int i = 0; i < 4; i++) begin
            bus_write(8'(8'h80 + i), 8'(i)); page_m[i] = 8'(i);
        end
        for (int i = 0; i < 4; i++) bus_read(8'(8'h80 + i), page_m[i], "R4 page walk");
        for (int i = 0; i < 4; i++) begin
            bus_write(8'(8'h80 + i), 8'(3 - i)); page_m[i] = 8'(3 - i);
        end
        bus_write(8'h82, 8'hA5); page_m[2] = 8'hA5;
        for (int i = 0; i < 4; i++) bus_read(8'(8'h80 + i), page_m[i], "R4 page independence");
        // R5/R8: writes to identity, reserved and unmapped space
        bus_write(8'h00, 8'hAA);
        bus_write(8'h01, 8'hAA);
        bus_write(8'h04, 8'h77);
        bus_write(8'h10, 8'h55);
        bus_write(8'h4F, 8'h55);
        bus_write(8'h6F, 8'h66);
        bus_write(8'h84, 8'h66);
        bus_write(8'hFF, 8'h66);
        bus_read(8'h00, 8'h3D, "R5 ident 0 after writes");
        bus_read(8'h01, 8'h01, "R5 ident 1 after writes");
        bus_read(8'h04, 8'h00, "R8 ident tail");
        bus_read(8'h10, 8'h00, "R8 reserved low");
        bus_read(8'h25, 8'h00, "R8 reserved mid");
        bus_read(8'h4F, 8'h00, "R8 reserved high");
        bus_read(8'h6F, 8'h00, "R8 below diag");
        bus_read(8'h84, 8'h00, "R8 past page");
        bus_read(8'hFF, 8'h00, "R8 top address");
        bus_read(8'h70, diag_m[0], "R8 diag untouched");
        bus_read(8'h83, page_m[3], "R8 page untouched");
        // R2: partial strobes do not write
        bus_write(8'h71, 8'h11, 1, 0, 0, 1);
        bus_write(8'h72, 8'h22, 0, 1, 0, 1);
        bus_write(8'h73, 8'h33, 0, 0, 1, 1);
        bus_write(8'h74, 8'h44, 0, 0, 0, 0);
        bus_read(8'h71, diag_m[1], "R2 cs high");
        bus_read(8'h72, diag_m[2], "R2 ads high");
        bus_read(8'h73, diag_m[3], "R2 we high");
        bus_read(8'h74, diag_m[4], "R2 oe low");
        // R9: reset in mid-run
        do_reset();
        bus_read(8'h7F, 8'h00, "R9 diag after reset");
        bus_read(8'h82, 8'h00, "R9 page after reset");
        bus_read(8'h00, 8'h3D, "R9 ident kept");
        finish_up();
    end

endmodule